// File: doc/BRIEF.md
# Management-Bus PHY Discovery and Selection

This controller runs a single discovery pass when asked to start. It visits every address on an MII management bus in ascending order. At each address it decides whether a transceiver answers. If one does, it reads that transceiver's two identifier registers and sorts it into a class using a small built-in identifier table. It picks one transceiver as the default. Every other transceiver is put into isolation with autonegotiation enabled, and the chosen one is released from isolation at the end of the pass.

The controller does not generate the serial MDIO frames itself. It hands register read and write requests to a separate MDIO master over a request/response handshake. When the pass ends it reports the selected address, a found flag and an error flag, together with a one-cycle done pulse. A typical use is to start it once after the system leaves reset and then use the reported address for all later management traffic.

Top module: `phy_scan_ctrl`

## Requirements
- R1: After `start`, addresses 0 to 31 are visited in ascending order. Each visit opens with two consecutive reads of register 1 (status), and only the second value is used.
- R2: An address whose second status value is 16'h0000 or 16'hFFFF counts as empty. It receives no further request.
- R3: For an occupied address, register 2 is read, then register 3. A table entry matches when register 2 equals its first word exactly and register 3 ANDed with 16'hFFF0 equals its second word. The entries are {0020,60C0}, {0282,F010}, {0141,0CC0} and {0000,8200}, and the `TYPE_MAP` parameter gives the class of each entry (2 bits per entry, entry 0 in bits 1:0; default all LAN).
- R4: The class codes are UNKNOWN=0, HOME=1, LAN=2 and MIX=3. A MIX entry becomes LAN when status bit 14 or bit 13 is set, and HOME otherwise. An identifier that matches no entry is UNKNOWN.
- R5: The default is the lowest occupied address whose status bit 2 (link) is set and whose class is not UNKNOWN. No request touches its control register during the scan.
- R6: Every other occupied address has register 0 read and then written back with bits 12 (autonegotiation enable) and 10 (isolate) set and all other bits kept. No register other than 0 is ever written.
- R7: When no default exists, the choice falls to the lowest HOME address, then the lowest LAN address, then the lowest occupied address.
- R8: After the scan, register 0 of the chosen address is read and written back with bit 10 cleared and all other bits kept. Two reads of register 1 follow.
- R9: When no address is occupied, `scan_err` is 1 and `found` is 0, and no request follows the last empty visit.
- R10: `done` is high for exactly one cycle at the end of a pass. `found`, `scan_err` and `sel_addr` are valid from that cycle until the next accepted start, and `found` and `scan_err` are never both 1.
- R11: A `start` that arrives while `busy` is high is ignored.
- R12: A request holds `req_valid` and all its fields from the cycle it appears until the cycle in which `resp_valid` is high. The next request may start in the following cycle.
- R13: During and directly after reset, `req_valid`, `busy`, `done`, `found` and `scan_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a pass (accepted only when idle) |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| found | output | 1 | A transceiver was selected |
| scan_err | output | 1 | No address responded |
| sel_addr | output | 5 | Selected transceiver address |
| req_valid | output | 1 | Management request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_phy | output | 5 | Target address of the request |
| req_reg | output | 5 | Target register of the request |
| req_wdata | output | 16 | Write data |
| resp_valid | input | 1 | Request completed this cycle |
| resp_rdata | input | 16 | Read data, valid with resp_valid |

## Verification
The handshake checks assume that the MDIO master raises `resp_valid` only while `req_valid` is high, for a single cycle per request. The bench's master model follows this: it latches a request when it sees it, answers after a fixed latency, and then drops the response in the next cycle. The properties on write content assume that reset values and transceiver registers can hold any pattern. For this reason the stimulus varies the initial control values from one address to the next, and it hides the link bit on the first status read of every transceiver, so that using the wrong read of the pair would change the choice.

// File: rtl/phy_scan_pkg.sv
// Shared definitions for the PHY discovery controller.
// Assumes a 16-bit management register file per transceiver.
package phy_scan_pkg;

    typedef enum logic [1:0] {
        PK_UNKNOWN = 2'd0,
        PK_HOME    = 2'd1,
        PK_LAN     = 2'd2,
        PK_MIX     = 2'd3
    } phy_kind_e;

    typedef enum logic [3:0] {
        S_IDLE, S_ST1, S_ST2, S_ID1, S_ID2, S_EVAL, S_CRD, S_CWR,
        S_NEXT, S_FRD, S_FWR, S_FS1, S_FS2, S_FIN
    } scan_state_e;

    localparam int TBL_N = 4;
    // entry 0 in the low word
    localparam logic [TBL_N-1:0][15:0] TBL_ID1 =
        {16'h0000, 16'h0141, 16'h0282, 16'h0020};
    localparam logic [TBL_N-1:0][15:0] TBL_ID2 =
        {16'h8200, 16'h0CC0, 16'hF010, 16'h60C0};
    localparam logic [15:0] ID2_MASK = 16'hFFF0;

    localparam int REG_CTL  = 0;
    localparam int REG_STAT = 1;
    localparam int REG_IDA  = 2;
    localparam int REG_IDB  = 3;

    localparam int CTL_ISO  = 10;
    localparam int CTL_ANEN = 12;
    localparam int ST_LINK  = 2;
    localparam int ST_100H  = 13;
    localparam int ST_100F  = 14;

endpackage

// File: rtl/phy_id_classify.sv
// Combinational classifier: matches an identifier pair against the built-in
// table (second word masked), then resolves MIX entries from the status word.
// Assumes id/status inputs are stable registers of the caller.
module phy_id_classify
    import phy_scan_pkg::*;
#(
    parameter logic [2*TBL_N-1:0] TYPE_MAP = {TBL_N{2'd2}}
) (
    input  logic [15:0] id_a,
    input  logic [15:0] id_b,
    input  logic [15:0] status,
    output phy_kind_e   kind
);

    logic [TBL_N-1:0] hit_vec;

    // Per-entry comparators
    generate
        for (genvar g = 0; g < TBL_N; g++) begin : g_cmp
            assign hit_vec[g] = (id_a == TBL_ID1[g]) &&
                                ((id_b & ID2_MASK) == TBL_ID2[g]);
        end
    endgenerate

    // First matching entry wins; MIX resolves on 100 Mb/s ability
    always_comb begin
        phy_kind_e raw;
        raw = PK_UNKNOWN;
        for (int i = TBL_N - 1; i >= 0; i--) begin
            if (hit_vec[i]) raw = phy_kind_e'(TYPE_MAP[2*i +: 2]);
        end
        if (raw == PK_MIX)
            kind = (status[ST_100F] || status[ST_100H]) ? PK_LAN : PK_HOME;
        else
            kind = raw;
    end

endmodule

// File: rtl/phy_pick_tracker.sv
// Remembers the best candidate of each kind seen during the scan and
// produces the final choice by fixed preference: linked, HOME, LAN, any.
// Assumes addresses arrive in ascending order, so first seen = lowest.
module phy_pick_tracker
    import phy_scan_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          upd,
    input  logic [AW-1:0] upd_addr,
    input  phy_kind_e     kind,
    input  logic          link,
    output logic          take_now,
    output logic          any_seen,
    output logic [AW-1:0] choice
);

    logic          lk_v, hm_v, ln_v;
    logic [AW-1:0] lk_a, hm_a, ln_a, an_a;

    // This PHY becomes the default if it is the first linked, known one
    assign take_now = link && (kind != PK_UNKNOWN) && !lk_v;

    // Capture first address of each candidate class
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            lk_v <= 1'b0; hm_v <= 1'b0; ln_v <= 1'b0; any_seen <= 1'b0;
            lk_a <= '0;   hm_a <= '0;   ln_a <= '0;   an_a <= '0;
        end else if (upd) begin
            if (take_now) begin
                lk_v <= 1'b1; lk_a <= upd_addr;
            end
            if (kind == PK_HOME && !hm_v) begin
                hm_v <= 1'b1; hm_a <= upd_addr;
            end
            if (kind == PK_LAN && !ln_v) begin
                ln_v <= 1'b1; ln_a <= upd_addr;
            end
            if (!any_seen) begin
                any_seen <= 1'b1; an_a <= upd_addr;
            end
        end
    end

    // Preference order for the final selection
    always_comb begin
        if (lk_v)      choice = lk_a;
        else if (hm_v) choice = hm_a;
        else if (ln_v) choice = ln_a;
        else           choice = an_a;
    end

endmodule

// File: rtl/phy_scan_ctrl.sv
// Top of the PHY discovery controller. Sequences management reads/writes
// through a request/response handshake: scan all addresses, classify,
// isolate non-default PHYs, then release the chosen one.
// Assumes resp_valid is a one-cycle pulse given only while req_valid is high.
module phy_scan_ctrl
    import phy_scan_pkg::*;
#(
    parameter int NUM_ADDR = 32,
    parameter int AW       = $clog2(NUM_ADDR),
    parameter int RW       = 5,
    parameter int DW       = 16,
    parameter logic [2*TBL_N-1:0] TYPE_MAP = {TBL_N{2'd2}}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          found,
    output logic          scan_err,
    output logic [AW-1:0] sel_addr,
    output logic          req_valid,
    output logic          req_write,
    output logic [AW-1:0] req_phy,
    output logic [RW-1:0] req_reg,
    output logic [DW-1:0] req_wdata,
    input  logic          resp_valid,
    input  logic [DW-1:0] resp_rdata
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(NUM_ADDR - 1);
    localparam logic [DW-1:0] ISO_M  = DW'(1) << CTL_ISO;
    localparam logic [DW-1:0] ANEN_M = DW'(1) << CTL_ANEN;

    scan_state_e   state;
    logic [AW-1:0] addr;
    logic [DW-1:0] stat_q, ida_q, idb_q, ctl_q;
    logic          found_q, err_q;
    logic [AW-1:0] sel_q;
    phy_kind_e     kind;
    logic          take_now, any_seen;
    logic [AW-1:0] choice;

    phy_id_classify #(.TYPE_MAP(TYPE_MAP)) u_cls (
        .id_a   (ida_q),
        .id_b   (idb_q),
        .status (stat_q),
        .kind   (kind)
    );

    phy_pick_tracker #(.AW(AW)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state == S_IDLE && start),
        .upd      (state == S_EVAL),
        .upd_addr (addr),
        .kind     (kind),
        .link     (stat_q[ST_LINK]),
        .take_now (take_now),
        .any_seen (any_seen),
        .choice   (choice)
    );

    // Decode the pending management request from the current state
    always_comb begin
        req_valid = 1'b1;
        req_write = 1'b0;
        req_reg   = RW'(REG_STAT);
        req_wdata = '0;
        unique case (state)
            S_ST1, S_ST2, S_FS1, S_FS2: req_reg = RW'(REG_STAT);
            S_ID1:        req_reg = RW'(REG_IDA);
            S_ID2:        req_reg = RW'(REG_IDB);
            S_CRD, S_FRD: req_reg = RW'(REG_CTL);
            S_CWR: begin
                req_reg = RW'(REG_CTL); req_write = 1'b1;
                req_wdata = ctl_q | ANEN_M | ISO_M;
            end
            S_FWR: begin
                req_reg = RW'(REG_CTL); req_write = 1'b1;
                req_wdata = ctl_q & ~ISO_M;
            end
            default: req_valid = 1'b0;
        endcase
    end

    assign req_phy  = addr;
    assign busy     = (state != S_IDLE);
    assign done     = (state == S_FIN);
    assign found    = found_q;
    assign scan_err = err_q;
    assign sel_addr = sel_q;

    // Scan sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE; addr <= '0;
            stat_q <= '0; ida_q <= '0; idb_q <= '0; ctl_q <= '0;
            found_q <= 1'b0; err_q <= 1'b0; sel_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    addr <= '0; found_q <= 1'b0; err_q <= 1'b0; sel_q <= '0;
                    state <= S_ST1;
                end
                S_ST1: if (resp_valid) state <= S_ST2;
                S_ST2: if (resp_valid) begin
                    stat_q <= resp_rdata;
                    state  <= (resp_rdata == '0 || resp_rdata == '1) ? S_NEXT : S_ID1;
                end
                S_ID1: if (resp_valid) begin ida_q <= resp_rdata; state <= S_ID2; end
                S_ID2: if (resp_valid) begin idb_q <= resp_rdata; state <= S_EVAL; end
                S_EVAL: state <= take_now ? S_NEXT : S_CRD;
                S_CRD: if (resp_valid) begin ctl_q <= resp_rdata; state <= S_CWR; end
                S_CWR: if (resp_valid) state <= S_NEXT;
                S_NEXT: begin
                    if (addr == LAST_ADDR) begin
                        if (any_seen) begin
                            addr <= choice; state <= S_FRD;
                        end else begin
                            err_q <= 1'b1; state <= S_FIN;
                        end
                    end else begin
                        addr <= addr + 1'b1; state <= S_ST1;
                    end
                end
                S_FRD: if (resp_valid) begin ctl_q <= resp_rdata; state <= S_FWR; end
                S_FWR: if (resp_valid) state <= S_FS1;
                S_FS1: if (resp_valid) state <= S_FS2;
                S_FS2: if (resp_valid) begin
                    found_q <= 1'b1; sel_q <= addr; state <= S_FIN;
                end
                S_FIN: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/phy_scan_chk.sv
// Property checker for phy_scan_ctrl, attached by bind.
// Assumes the MDIO master answers only while a request is pending.
module phy_scan_chk #(
    parameter int AW = 5,
    parameter int RW = 5,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          found,
    input logic          scan_err,
    input logic          req_valid,
    input logic          req_write,
    input logic [AW-1:0] req_phy,
    input logic [RW-1:0] req_reg,
    input logic [DW-1:0] req_wdata,
    input logic          resp_valid
);

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !resp_valid) |=> (req_valid && $stable(req_phy) &&
            $stable(req_reg) && $stable(req_write) && $stable(req_wdata)));

    assert_write_ctl_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> (req_reg == '0));

    assert_iso_with_anen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_wdata[10]) |-> req_wdata[12]);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(found && scan_err));

    assert_done_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (found ^ scan_err));

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);

    assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

bind phy_scan_ctrl phy_scan_chk #(.AW(AW), .RW(RW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .found      (found),
    .scan_err   (scan_err),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_phy    (req_phy),
    .req_reg    (req_reg),
    .req_wdata  (req_wdata),
    .resp_valid (resp_valid)
);

// File: tb/phy_scan_ctrl_tb_top.sv
// Self-checking bench: an MDIO register model with latched link on the
// first status read, and expected outcomes computed from the requirements.
module phy_scan_ctrl_tb_top;

    localparam logic [7:0] TMAP = {2'd1, 2'd2, 2'd3, 2'd2}; // e3 HOME, e2 LAN, e1 MIX, e0 LAN
    localparam int LAT = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, found, scan_err;
    logic [4:0]  sel_addr, req_phy, req_reg;
    logic        req_valid, req_write;
    logic [15:0] req_wdata;
    logic        resp_valid = 1'b0;
    logic [15:0] resp_rdata = 16'h0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    phy_scan_ctrl #(.TYPE_MAP(TMAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .found(found), .scan_err(scan_err), .sel_addr(sel_addr),
        .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy),
        .req_reg(req_reg), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata)
    );

    // Transceiver model state
    bit          m_pres  [32];
    bit          m_latch [32];
    logic [15:0] m_ida [32], m_idb [32], m_stat [32], m_ctl [32], m_ctl0 [32];
    int          txn = 0;
    int          bad_wr = 0;

    localparam logic [15:0] B_ID1 [4] = '{16'h0020, 16'h0282, 16'h0141, 16'h0000};
    localparam logic [15:0] B_ID2 [4] = '{16'h60C0, 16'hF010, 16'h0CC0, 16'h8200};

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // MDIO master model: latch at negedge, answer after LAT cycles
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && req_valid) begin
                automatic int          p = int'(req_phy);
                automatic int          r = int'(req_reg);
                automatic bit          w = req_write;
                automatic logic [15:0] d = req_wdata;
                automatic logic [15:0] q = 16'hFFFF;
                repeat (LAT) @(negedge clk);
                txn++;
                if (w && (r != 0 || !m_pres[p])) bad_wr++;
                if (!m_pres[p]) begin
                    if (r == 1) q = p[0] ? 16'hFFFF : 16'h0000;
                end else begin
                    case (r)
                        0: begin q = m_ctl[p]; if (w) m_ctl[p] = d; end
                        1: begin
                            q = m_latch[p] ? (m_stat[p] & ~16'h0004) : m_stat[p];
                            m_latch[p] = 1'b0;
                        end
                        2: q = m_ida[p];
                        3: q = m_idb[p];
                        default: q = 16'h0000;
                    endcase
                end
                resp_rdata = q;
                resp_valid = 1'b1;
                @(negedge clk);
                resp_valid = 1'b0;
            end
        end
    end

    task automatic clear_phys();
        for (int a = 0; a < 32; a++) begin
            m_pres[a] = 0; m_latch[a] = 0;
            m_ida[a] = 0; m_idb[a] = 0; m_stat[a] = 0; m_ctl[a] = 0; m_ctl0[a] = 0;
        end
    endtask

    task automatic add_phy(input int a, input logic [15:0] i1, input logic [15:0] i2,
                           input logic [15:0] st);
        m_pres[a] = 1; m_latch[a] = 1;
        m_ida[a] = i1; m_idb[a] = i2; m_stat[a] = st;
        m_ctl0[a] = 16'h0100 | 16'(a) | (16'(a & 3) << 12);
        m_ctl[a] = m_ctl0[a];
    endtask

    // Class per R3/R4: 0 UNKNOWN, 1 HOME, 2 LAN
    function automatic int kind_of(input int a);
        int k = 0;
        for (int e = 3; e >= 0; e--)
            if (m_ida[a] == B_ID1[e] && (m_idb[a] & 16'hFFF0) == B_ID2[e])
                k = int'(TMAP[2*e +: 2]);
        if (k == 3) k = (m_stat[a][14] || m_stat[a][13]) ? 2 : 1;
        return k;
    endfunction

    task automatic run_scan(input string tag, input bit poke);
        int lk = -1, hm = -1, ln = -1, an = -1, ch, exp_txn = 0;
        bit ok_ctl = 1, got = 0;
        for (int a = 0; a < 32; a++) begin
            if (!m_pres[a]) begin exp_txn += 2; continue; end
            exp_txn += 4;
            if (lk < 0 && m_stat[a][2] && kind_of(a) != 0) lk = a;
            else exp_txn += 2;
            if (hm < 0 && kind_of(a) == 1) hm = a;
            if (ln < 0 && kind_of(a) == 2) ln = a;
            if (an < 0) an = a;
        end
        ch = (lk >= 0) ? lk : (hm >= 0) ? hm : (ln >= 0) ? ln : an;
        if (an >= 0) exp_txn += 4;
        txn = 0; bad_wr = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        for (int c = 0; c < 5000; c++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        chk(got, {tag, " R10 done seen"}, got, 1);
        chk(found == (an >= 0), {tag, " R10 found"}, found, an >= 0);
        chk(scan_err == (an < 0), {tag, " R9 scan_err"}, scan_err, an < 0);
        if (an >= 0) chk(sel_addr == 5'(ch), {tag, " R5 R7 sel_addr"}, sel_addr, ch);
        chk(txn == exp_txn, {tag, " R1 R2 R11 R12 request count"}, txn, exp_txn);
        chk(bad_wr == 0, {tag, " R6 R9 stray writes"}, bad_wr, 0);
        for (int a = 0; a < 32; a++) begin
            if (m_pres[a]) begin
                automatic logic [15:0] e = (a == lk) ? m_ctl0[a] : (m_ctl0[a] | 16'h1400);
                if (a == ch) e = e & ~16'h0400;
                if (m_ctl[a] !== e) begin
                    ok_ctl = 0;
                    chk(0, {tag, " R6 R8 ctl"}, m_ctl[a], e);
                end
            end
        end
        if (ok_ctl) chk(1, {tag, " R6 R8 ctl"}, 0, 0);
        @(negedge clk);
        chk(!done, {tag, " R10 pulse width"}, done, 0);
    endtask

    // Global watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        clear_phys();
        repeat (3) @(negedge clk);
        chk(!req_valid && !busy && !done && !found && !scan_err, "R13 in reset",
            {req_valid, busy, done, found, scan_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req_valid && !busy && !done && !found && !scan_err, "R13 after reset",
            {req_valid, busy, done, found, scan_err}, 0);

        // empty bus
        clear_phys(); run_scan("empty", 0);

        // unknown linked, LAN with revision nibble, HOME: HOME preferred
        clear_phys();
        add_phy(3, 16'h1234, 16'h5678, 16'h782D);
        add_phy(7, 16'h0020, 16'h60C5, 16'h7809);
        add_phy(20, 16'h0000, 16'h8203, 16'h7809);
        run_scan("R3 R7 home-pref", 0);

        // MIX->LAN, linked LAN and HOME: first linked wins; start ignored
        clear_phys();
        add_phy(1, 16'h0282, 16'hF01A, 16'h6009);
        add_phy(9, 16'h0141, 16'h0CC3, 16'h780D);
        add_phy(12, 16'h0000, 16'h8200, 16'h780D);
        run_scan("R4 R5 R11 link-first", 1);

        // MIX without 100 Mb/s -> HOME beats lower LAN
        clear_phys();
        add_phy(2, 16'h0020, 16'h60C0, 16'h7809);
        add_phy(5, 16'h0282, 16'hF010, 16'h0809);
        run_scan("R4 R7 mix-home", 0);

        // only unknown PHYs: lowest responding address
        clear_phys();
        add_phy(30, 16'hABCD, 16'h1111, 16'h780D);
        add_phy(31, 16'hABCD, 16'h2222, 16'h7809);
        run_scan("R7 fallback", 0);

        // sweep: one PHY at each address, every table entry
        for (int a = 0; a < 32; a++) begin
            clear_phys();
            add_phy(a, B_ID1[a % 4], B_ID2[a % 4] | 16'(a & 15),
                    16'h0809 | ((a % 3 == 0) ? 16'h0004 : 16'h0) | ((a % 2) ? 16'h6000 : 16'h0));
            run_scan("R1 R3 sweep single", 0);
        end

        // sweep: LAN below HOME, neither linked
        for (int a = 0; a < 31; a += 3) begin
            clear_phys();
            add_phy(a, 16'h0141, 16'h0CC0, 16'h7809);
            add_phy(a + 1, 16'h0000, 16'h8201, 16'h7809);
            run_scan("R7 sweep pair", 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule